// File: doc/BRIEF.md
# Delayed Synapse Activation Scheduler

This block holds synapse activations that must reach their targets some time after the spike that caused them. A dispatcher hands it entries made of a synapse address, a per-connection delay in time ticks and a conductance value. Each entry is filed into a ring of time slots at the slot that lies the given number of ticks ahead of the current time pointer. When the pointer reaches that slot, the block drives the stored entries out one per cycle. Each output carries the synapse address split into a row field and a column field, the conductance, and a one-cycle activate strobe.

A second input carries activations that need no delay. They use the same output port, and they always win it. A pending release simply waits a cycle when this happens. If a write finds its target slot full, the entry is dropped and an overflow pulse is raised. A sticky flag records the event until reset.

Top module: `dly_act_sched`

## Requirements
- R1: After reset act_o, act_row_o, act_col_o, act_cond_o, ovf_o and ovf_sticky_o are all zero, the time pointer is 0 and every slot is empty.
- R2: An immediate request in a cycle gives act_o high in the next cycle. act_row_o then equals the upper ROW_W bits of imm_addr_i, act_col_o equals its lower COL_W bits, and act_cond_o equals imm_cond_i. In any cycle with no activation the three data outputs are zero.
- R3: A write with delay d from 1 to SLOTS-1 is stored in slot (base + d) mod SLOTS. The base is the time pointer, or the pointer plus one in a cycle where a tick is accepted.
- R4: An accepted tick advances the pointer by one and starts draining the slot the pointer now names. Its first entry appears on act_o two cycles after the tick is sampled.
- R5: A slot releases its entries one per cycle, in the order they were written. Its occupancy returns to zero when the drain ends, one cycle after the last entry is released.
- R6: An immediate request takes the output in a cycle where a release is due. The release is held back by one cycle and is not lost.
- R7: A tick that arrives while a slot is still draining is ignored. The pointer does not move.
- R8: A write with delay 0 is ignored. Nothing is stored and no overflow is raised.
- R9: A write to a slot already holding DEPTH entries is dropped. ovf_o is high for exactly the next cycle, and ovf_sticky_o goes high in that cycle and stays high until reset.
- R10: A drained slot offers its full DEPTH entries again when the pointer wraps around to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time tick request |
| wr_valid_i | input | 1 | Delayed entry valid |
| wr_delay_i | input | $clog2(SLOTS) | Delay in ticks |
| wr_addr_i | input | ROW_W+COL_W | Synapse address, row in upper bits |
| wr_cond_i | input | COND_W | Conductance of the delayed entry |
| imm_valid_i | input | 1 | Immediate activation valid |
| imm_addr_i | input | ROW_W+COL_W | Immediate synapse address |
| imm_cond_i | input | COND_W | Immediate conductance |
| act_o | output | 1 | Activate strobe |
| act_row_o | output | ROW_W | Row field of activated synapse |
| act_col_o | output | COL_W | Column field of activated synapse |
| act_cond_o | output | COND_W | Conductance of activation |
| ovf_o | output | 1 | One-cycle drop pulse |
| ovf_sticky_o | output | 1 | Sticky drop flag |

## Verification
Two events can claim the single output in the same cycle: a slot release, and an immediate activation. The bench fills a slot with several entries, ticks, and then holds the immediate input high during the cycles where the releases are due. A queue-based model predicts every cycle that the immediate value appears first and that each stalled release follows, still in order. The same per-cycle comparison covers writes that coincide with an accepted tick, where the base of the delay has already moved, and ticks that arrive during a drain.

// File: rtl/dly_sched_pkg.sv
package dly_sched_pkg;
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_IMM  = 2'd1,
      SRC_DLY  = 2'd2
   } out_src_e;
endpackage

// File: rtl/dly_time_ptr.sv
module dly_time_ptr #(
   parameter int SLOTS = 16,
   localparam int PTR_W = $clog2(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             busy_i,
   output logic [PTR_W-1:0] now_o,
   output logic [PTR_W-1:0] base_o,
   output logic             tick_acc_o
);
   logic [PTR_W-1:0] now_q;

   assign tick_acc_o = tick_i & ~busy_i;
   assign base_o     = now_q + PTR_W'(tick_acc_o);
   assign now_o      = now_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) now_q <= '0;
      else        now_q <= base_o;
   end
endmodule

// File: rtl/dly_slot_store.sv
module dly_slot_store #(
   parameter int SLOTS = 16,
   parameter int DEPTH = 8,
   parameter int ENT_W = 12,
   localparam int PTR_W = $clog2(SLOTS),
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_valid_i,
   input  logic [PTR_W-1:0] wr_delay_i,
   input  logic [ENT_W-1:0] wr_data_i,
   input  logic [PTR_W-1:0] base_i,
   input  logic [PTR_W-1:0] rd_slot_i,
   input  logic [IDX_W-1:0] rd_idx_i,
   input  logic             clr_i,
   output logic [ENT_W-1:0] rd_data_o,
   output logic [CNT_W-1:0] rd_cnt_o,
   output logic             reject_o
);
   logic [SLOTS-1:0][CNT_W-1:0] occ_a;
   logic [ENT_W-1:0]            mem_q [SLOTS][DEPTH];
   logic [PTR_W-1:0]            tgt;
   logic                        req, full, wr_ok;

   assign tgt      = base_i + wr_delay_i;
   assign req      = wr_valid_i && (wr_delay_i != '0);
   assign full     = (occ_a[tgt] == CNT_W'(DEPTH));
   assign wr_ok    = req && !full;
   assign reject_o = req && full;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [CNT_W-1:0] occ_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    occ_q <= '0;
         else if (clr_i && (rd_slot_i == PTR_W'(s)))    occ_q <= '0;
         else if (wr_ok && (tgt == PTR_W'(s)))          occ_q <= occ_q + 1'b1;
      end
      assign occ_a[s] = occ_q;
   end

   always_ff @(posedge clk) begin
      if (wr_ok) mem_q[tgt][occ_a[tgt][IDX_W-1:0]] <= wr_data_i;
   end

   assign rd_data_o = mem_q[rd_slot_i][rd_idx_i];
   assign rd_cnt_o  = occ_a[rd_slot_i];
endmodule

// File: rtl/dly_out_stage.sv
module dly_out_stage
   import dly_sched_pkg::*;
#(
   parameter int ROW_W    = 4,
   parameter int COL_W    = 4,
   parameter int COND_W   = 4,
   parameter bit HAS_COND = 1'b1,
   localparam int ADDR_W  = ROW_W + COL_W,
   localparam int ENT_W   = ADDR_W + COND_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              imm_valid_i,
   input  logic [ADDR_W-1:0] imm_addr_i,
   input  logic [COND_W-1:0] imm_cond_i,
   input  logic              dly_valid_i,
   input  logic [ENT_W-1:0]  dly_data_i,
   output logic              dly_adv_o,
   output logic              act_o,
   output logic [ROW_W-1:0]  act_row_o,
   output logic [COL_W-1:0]  act_col_o,
   output logic [COND_W-1:0] act_cond_o
);
   out_src_e          src;
   logic [ADDR_W-1:0] sel_addr;
   logic [COND_W-1:0] sel_cond;

   always_comb begin
      src      = SRC_NONE;
      sel_addr = '0;
      sel_cond = '0;
      if (imm_valid_i) begin
         src      = SRC_IMM;
         sel_addr = imm_addr_i;
         sel_cond = imm_cond_i;
      end else if (dly_valid_i) begin
         src      = SRC_DLY;
         sel_addr = dly_data_i[ENT_W-1 -: ADDR_W];
         sel_cond = dly_data_i[COND_W-1:0];
      end
   end

   assign dly_adv_o = (src == SRC_DLY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_o     <= 1'b0;
         act_row_o <= '0;
         act_col_o <= '0;
      end else begin
         act_o     <= (src != SRC_NONE);
         act_row_o <= sel_addr[ADDR_W-1:COL_W];
         act_col_o <= sel_addr[COL_W-1:0];
      end
   end

   if (HAS_COND) begin : g_cond
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) act_cond_o <= '0;
         else        act_cond_o <= sel_cond;
      end
   end else begin : g_nocond
      assign act_cond_o = '0;
   end
endmodule

// File: rtl/dly_act_sched.sv
module dly_act_sched #(
   parameter int SLOTS    = 16,
   parameter int DEPTH    = 8,
   parameter int ROW_W    = 4,
   parameter int COL_W    = 4,
   parameter int COND_W   = 4,
   parameter bit HAS_COND = 1'b1,
   localparam int PTR_W   = $clog2(SLOTS),
   localparam int IDX_W   = $clog2(DEPTH),
   localparam int CNT_W   = $clog2(DEPTH + 1),
   localparam int ADDR_W  = ROW_W + COL_W,
   localparam int ENT_W   = ADDR_W + COND_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              wr_valid_i,
   input  logic [PTR_W-1:0]  wr_delay_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [COND_W-1:0] wr_cond_i,
   input  logic              imm_valid_i,
   input  logic [ADDR_W-1:0] imm_addr_i,
   input  logic [COND_W-1:0] imm_cond_i,
   output logic              act_o,
   output logic [ROW_W-1:0]  act_row_o,
   output logic [COL_W-1:0]  act_col_o,
   output logic [COND_W-1:0] act_cond_o,
   output logic              ovf_o,
   output logic              ovf_sticky_o
);
   if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("SLOTS must be a power of two of at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if (ROW_W < 1 || COL_W < 1 || COND_W < 1) begin : g_bad_width
      $error("field widths must be at least 1");
   end

   logic             busy_q;
   logic [CNT_W-1:0] idx_q;
   logic [PTR_W-1:0] now, base;
   logic             tick_acc, reject, clr, has_next, adv;
   logic [ENT_W-1:0] rd_data;
   logic [CNT_W-1:0] rd_cnt;

   dly_time_ptr #(.SLOTS(SLOTS)) u_ptr (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .busy_i(busy_q),
      .now_o(now), .base_o(base), .tick_acc_o(tick_acc)
   );

   dly_slot_store #(.SLOTS(SLOTS), .DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_valid_i(wr_valid_i), .wr_delay_i(wr_delay_i),
      .wr_data_i({wr_addr_i, wr_cond_i}), .base_i(base),
      .rd_slot_i(now), .rd_idx_i(idx_q[IDX_W-1:0]), .clr_i(clr),
      .rd_data_o(rd_data), .rd_cnt_o(rd_cnt), .reject_o(reject)
   );

   assign has_next = busy_q && (idx_q < rd_cnt);
   assign clr      = busy_q && !has_next;

   dly_out_stage #(.ROW_W(ROW_W), .COL_W(COL_W), .COND_W(COND_W),
                   .HAS_COND(HAS_COND)) u_out (
      .clk(clk), .rst_n(rst_n),
      .imm_valid_i(imm_valid_i), .imm_addr_i(imm_addr_i), .imm_cond_i(imm_cond_i),
      .dly_valid_i(has_next), .dly_data_i(rd_data), .dly_adv_o(adv),
      .act_o(act_o), .act_row_o(act_row_o), .act_col_o(act_col_o),
      .act_cond_o(act_cond_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else if (tick_acc) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
      end else if (clr) begin
         busy_q <= 1'b0;
      end else if (adv) begin
         idx_q  <= idx_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_o        <= 1'b0;
         ovf_sticky_o <= 1'b0;
      end else begin
         ovf_o        <= reject;
         ovf_sticky_o <= ovf_sticky_o | reject;
      end
   end
endmodule

// File: rtl/dly_act_sched_chk.sv
module dly_act_sched_chk #(
   parameter int ROW_W    = 4,
   parameter int COL_W    = 4,
   parameter int COND_W   = 4,
   parameter int PTR_W    = 4,
   parameter bit HAS_COND = 1'b1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   tick_i,
   input logic                   wr_valid_i,
   input logic [PTR_W-1:0]       wr_delay_i,
   input logic [ROW_W+COL_W-1:0] wr_addr_i,
   input logic [COND_W-1:0]      wr_cond_i,
   input logic                   imm_valid_i,
   input logic [ROW_W+COL_W-1:0] imm_addr_i,
   input logic [COND_W-1:0]      imm_cond_i,
   input logic                   act_o,
   input logic [ROW_W-1:0]       act_row_o,
   input logic [COL_W-1:0]       act_col_o,
   input logic [COND_W-1:0]      act_cond_o,
   input logic                   ovf_o,
   input logic                   ovf_sticky_o
);
   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (!act_o && !ovf_o && !ovf_sticky_o));

   assert_imm_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
      imm_valid_i |=> (act_o && {act_row_o, act_col_o} == $past(imm_addr_i)
                       && (!HAS_COND || act_cond_o == $past(imm_cond_i))));

   assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !act_o |-> (act_row_o == '0 && act_col_o == '0 && act_cond_o == '0));

   assert_zero_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_i && wr_delay_i == '0) |=> !ovf_o);

   assert_pulse_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> ovf_sticky_o);

   assert_flag_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_sticky_o |=> ovf_sticky_o);
endmodule

bind dly_act_sched dly_act_sched_chk #(
   .ROW_W(ROW_W), .COL_W(COL_W), .COND_W(COND_W), .PTR_W(PTR_W), .HAS_COND(HAS_COND)
) u_chk (.*);

// File: tb/dly_act_sched_tb.sv
module dly_act_sched_tb;
   localparam int CLK_PERIOD = 10;
   localparam int SLOTS = 16;
   localparam int DEPTH = 8;
   localparam int ROW_W = 4;
   localparam int COL_W = 4;
   localparam int COND_W = 4;
   localparam int PTR_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_i = 1'b0;
   logic wr_valid_i = 1'b0;
   logic [PTR_W-1:0] wr_delay_i = '0;
   logic [ROW_W+COL_W-1:0] wr_addr_i = '0;
   logic [COND_W-1:0] wr_cond_i = '0;
   logic imm_valid_i = 1'b0;
   logic [ROW_W+COL_W-1:0] imm_addr_i = '0;
   logic [COND_W-1:0] imm_cond_i = '0;
   logic act_o, ovf_o, ovf_sticky_o;
   logic [ROW_W-1:0] act_row_o;
   logic [COL_W-1:0] act_col_o;
   logic [COND_W-1:0] act_cond_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   dly_act_sched u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .wr_valid_i(wr_valid_i), .wr_delay_i(wr_delay_i), .wr_addr_i(wr_addr_i),
      .wr_cond_i(wr_cond_i), .imm_valid_i(imm_valid_i), .imm_addr_i(imm_addr_i),
      .imm_cond_i(imm_cond_i), .act_o(act_o), .act_row_o(act_row_o),
      .act_col_o(act_col_o), .act_cond_o(act_cond_o), .ovf_o(ovf_o),
      .ovf_sticky_o(ovf_sticky_o)
   );

   int checks = 0;
   int failures = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   int q[SLOTS][$];
   int m_now = 0;
   bit m_busy = 1'b0;
   int e_act = 0, e_row = 0, e_col = 0, e_cond = 0, e_ovf = 0, e_sticky = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SLOTS; s++) q[s].delete();
         m_now = 0; m_busy = 0;
         e_act = 0; e_row = 0; e_col = 0; e_cond = 0; e_ovf = 0; e_sticky = 0;
      end else begin
         bit b0;
         bit tacc;
         int base, t, v;
         b0 = m_busy;
         e_act = 0; e_row = 0; e_col = 0; e_cond = 0; e_ovf = 0;
         if (m_busy && q[m_now].size() == 0) m_busy = 0;
         if (imm_valid_i) begin
            e_act = 1;
            e_row = int'(imm_addr_i) / (1 << COL_W);
            e_col = int'(imm_addr_i) % (1 << COL_W);
            e_cond = int'(imm_cond_i);
         end else if (m_busy) begin
            v = q[m_now].pop_front();
            e_act = 1;
            e_cond = v % (1 << COND_W);
            v = v / (1 << COND_W);
            e_row = v / (1 << COL_W);
            e_col = v % (1 << COL_W);
         end
         tacc = tick_i && !b0;
         base = tacc ? (m_now + 1) % SLOTS : m_now;
         if (wr_valid_i && wr_delay_i != 0) begin
            t = (base + int'(wr_delay_i)) % SLOTS;
            if (q[t].size() >= DEPTH) e_ovf = 1;
            else q[t].push_back(int'(wr_addr_i) * (1 << COND_W) + int'(wr_cond_i));
         end
         if (tacc) begin m_now = base; m_busy = 1; end
         if (e_ovf != 0) e_sticky = 1;
      end
   end

   task automatic chk(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         chk("act", int'(act_o), e_act);
         chk("row", int'(act_row_o), e_row);
         chk("col", int'(act_col_o), e_col);
         chk("cond", int'(act_cond_o), e_cond);
         chk("ovf", int'(ovf_o), e_ovf);
         chk("sticky", int'(ovf_sticky_o), e_sticky);
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic put(input int d, input int a, input int c);
      wr_valid_i = 1'b1; wr_delay_i = PTR_W'(d);
      wr_addr_i = (ROW_W+COL_W)'(a); wr_cond_i = COND_W'(c);
      @(negedge clk);
      wr_valid_i = 1'b0;
   endtask

   task automatic tick_gap(input int gap);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      idle(gap);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired during %s", cur_req);
      finish_run();
   end

   initial begin
      // R1: reset state
      idle(3);
      rst_n = 1'b1;
      idle(2);
      cur_req = "R1";
      chk("reset act R1", int'(act_o), 0);
      chk("reset sticky R1", int'(ovf_sticky_o), 0);

      // R2: immediate path, varied patterns
      cur_req = "R2";
      for (int i = 0; i < 6; i++) begin
         imm_valid_i = 1'b1; imm_addr_i = 8'(i * 37 + 5); imm_cond_i = 4'(i + 9);
         @(negedge clk);
      end
      imm_valid_i = 1'b0;
      idle(3);

      // R3 / R4: single delayed entry released after its delay
      cur_req = "R3";
      put(3, 8'h5A, 7);
      cur_req = "R4";
      for (int i = 0; i < 4; i++) tick_gap(12);

      // R3: write in the cycle of an accepted tick, delay 1 counts from new time
      cur_req = "R3";
      tick_i = 1'b1; wr_valid_i = 1'b1; wr_delay_i = 4'd1; wr_addr_i = 8'hC3; wr_cond_i = 4'd2;
      @(negedge clk);
      tick_i = 1'b0; wr_valid_i = 1'b0;
      idle(12);
      tick_gap(12);

      // R5: several entries in one slot, ordered release
      cur_req = "R5";
      put(2, 8'h11, 1); put(2, 8'h22, 2); put(2, 8'h33, 3);
      tick_gap(12); tick_gap(14);

      // R6: immediate collides with drain
      cur_req = "R6";
      put(1, 8'h41, 4); put(1, 8'h42, 5); put(1, 8'h43, 6); put(1, 8'h44, 7);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      @(negedge clk);
      imm_valid_i = 1'b1; imm_addr_i = 8'hF0; imm_cond_i = 4'hE;
      @(negedge clk);
      imm_addr_i = 8'h0F; imm_cond_i = 4'h1;
      @(negedge clk);
      imm_valid_i = 1'b0;
      idle(10);

      // R7: tick during a drain is ignored
      cur_req = "R7";
      put(1, 8'h71, 1); put(1, 8'h72, 2); put(1, 8'h73, 3); put(2, 8'h74, 4);
      tick_i = 1'b1;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      tick_i = 1'b0;
      idle(10);
      tick_gap(12);

      // R8: zero delay writes do nothing
      cur_req = "R8";
      for (int i = 0; i < 10; i++) put(0, 8'h80 + i, 3);
      tick_gap(12); tick_gap(12);

      // R9: overflow of a full slot
      cur_req = "R9";
      for (int i = 0; i < DEPTH + 2; i++) put(5, 8'h90 + i, i);
      idle(3);
      for (int i = 0; i < 6; i++) tick_gap(14);

      // R10: wrap around, slots reused at full capacity
      cur_req = "R10";
      for (int k = 0; k < SLOTS + 2; k++) begin
         for (int i = 0; i < DEPTH; i++) put(15, (k * 8 + i) % 256, (k + i) % 16);
         put(((k % 14) + 1), 8'hA0 + k, k % 16);
         tick_gap(DEPTH + 6);
      end
      for (int k = 0; k < SLOTS; k++) tick_gap(DEPTH + 6);

      idle(5);
      finish_run();
   end
endmodule